// File: doc/BRIEF.md
# Dual-Bank Phase Accumulator Oscillator

This block is the digital core of a direct digital synthesizer. On every master clock edge a 28-bit phase accumulator advances by one of two programmed frequency tuning words and wraps modulo 2^28. The output frequency is therefore the tuning word times the clock frequency divided by 2^28. A second pair of 12-bit words holds phase offsets. The chosen offset is added to the top 12 bits of the accumulator, and the 12-bit sum is handed to a downstream waveform stage as a registered phase value. One offset step is one 4096th of a turn.

Software loads the four words through a parallel write port that carries a target code and a data word. Which frequency word and which offset word are in use can come from two control inputs that software drives, or from two free-running select pins. The pins pass through a two-flop synchronizer before they are used. Frequency or phase modulation is done by switching between banks. Switching banks never restarts the accumulator, so the phase stays continuous. A synchronous reset clears the accumulator, the phase output and the synchronizers, and it leaves all four programmed words as they were.

Top module: `dual_bank_nco`

## Requirements
- R1: At each rising edge with `rst` low, `acc_out` becomes its previous value plus the selected frequency word, modulo 2^28.
- R2: With `use_pins` = 0, the frequency word applied at an edge is bank `ctl_fsel` (0 selects bank 0, 1 selects bank 1), as sampled at that same edge.
- R3: At each rising edge with `rst` low, `phase_out` becomes the value of `acc_out[27:16]` before that edge plus the selected offset word, so it trails the accumulator by one register.
- R4: With `use_pins` = 0, the offset word applied at an edge is bank `ctl_psel`, as sampled at that same edge.
- R5: With `use_pins` = 1, the banks follow `fsel_pin` and `psel_pin` through two flops. A pin level first present at edge k is applied to the update at edge k+2.
- R6: A change of frequency bank does not reset or step the accumulator. The new word is simply added from the edge at which it is selected.
- R7: While `rst` is high, each edge sets `acc_out`, `phase_out` and both synchronizers to zero. The four programmed words keep their values across the reset.
- R8: A word written at edge k is used by the accumulator update (or the phase sum) at edge k+1 and later, whether or not its bank is active.
- R9: The 12-bit phase sum wraps modulo 4096 without saturation.
- R10: When `wr_en` = 1, `wr_sel` names the target: 0 = frequency bank 0, 1 = frequency bank 1, 2 = offset bank 0, 3 = offset bank 1. Offset writes take `wr_data[11:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high datapath reset |
| wr_en | input | 1 | Write strobe for the word registers |
| wr_sel | input | 2 | Write target code |
| wr_data | input | 28 | Write data; offset writes use the low 12 bits |
| use_pins | input | 1 | 1: banks follow the pins, 0: banks follow the control bits |
| ctl_fsel | input | 1 | Frequency bank control bit |
| ctl_psel | input | 1 | Offset bank control bit |
| fsel_pin | input | 1 | Asynchronous frequency bank select pin |
| psel_pin | input | 1 | Asynchronous offset bank select pin |
| acc_out | output | 28 | Phase accumulator value |
| phase_out | output | 12 | Registered truncated phase with offset added |

## Verification
The accumulator result of an edge is visible right after that edge. The phase output reflects the accumulator value from one edge earlier. A pin change reaches the arithmetic two edges after it is first sampled, and a written word reaches it one edge after the write. The bench mirrors these timings in a reference model that runs on each rising edge from the same inputs. The model pushes the expected accumulator and phase into a queue, and a monitor pops and compares them at the following falling edge. Each comparison therefore lands on exactly the cycle that the requirement names.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    TGT_FREQ0  = 2'd0,
    TGT_FREQ1  = 2'd1,
    TGT_PHASE0 = 2'd2,
    TGT_PHASE1 = 2'd3
  } wr_target_e;

  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/nco_word_bank.sv
module nco_word_bank
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PHS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             fsel,
  input  logic             psel,
  output logic [ACC_W-1:0] freq_word,
  output logic [PHS_W-1:0] phase_word
);

  logic [ACC_W-1:0] freq_q  [NUM_BANKS];
  logic [PHS_W-1:0] phase_q [NUM_BANKS];

  wr_target_e tgt;
  assign tgt = wr_target_e'(wr_sel);

  // One storage slot per bank; the reset input is deliberately absent here.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit_freq;
    logic hit_phase;
    assign hit_freq  = wr_en && (tgt == (b == 0 ? TGT_FREQ0 : TGT_FREQ1));
    assign hit_phase = wr_en && (tgt == (b == 0 ? TGT_PHASE0 : TGT_PHASE1));

    always_ff @(posedge clk) begin
      if (hit_freq)  freq_q[b]  <= wr_data;
      if (hit_phase) phase_q[b] <= wr_data[PHS_W-1:0];
    end
  end

  assign freq_word  = freq_q[fsel];
  assign phase_word = phase_q[psel];

  // Reset leaves programmed words alone (R7)
  assert_words_kept_R7 : assert property (@(posedge clk)
    (rst && !wr_en) |=> ($stable(freq_q[0]) && $stable(freq_q[1]) &&
                         $stable(phase_q[0]) && $stable(phase_q[1])));

endmodule

// File: rtl/nco_sel_ctrl.sv
module nco_sel_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic use_pins,
  input  logic ctl_fsel,
  input  logic ctl_psel,
  input  logic fsel_pin,
  input  logic psel_pin,
  output logic fsel_eff,
  output logic psel_eff
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] f_chain;
  logic [LAST:0] p_chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_chain <= '0;
      p_chain <= '0;
    end else begin
      f_chain[0] <= fsel_pin;
      p_chain[0] <= psel_pin;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        f_chain[i] <= f_chain[i-1];
        p_chain[i] <= p_chain[i-1];
      end
    end
  end

  logic f_synced;
  logic p_synced;
  assign f_synced = f_chain[LAST];
  assign p_synced = p_chain[LAST];

  assign fsel_eff = use_pins ? f_synced : ctl_fsel;
  assign psel_eff = use_pins ? p_synced : ctl_psel;

  if (SYNC_STAGES == 2) begin : g_sync_chk
    // Pin level appears at the synchronizer output two edges later (R5)
    assert_pin_sync_R5 : assert property (@(posedge clk) disable iff (rst)
      $rose(f_synced) |-> $past(fsel_pin, 2));
    assert_psel_sync_R5 : assert property (@(posedge clk) disable iff (rst)
      $rose(p_synced) |-> $past(psel_pin, 2));
  end

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core #(
  parameter int ACC_W = 28,
  parameter int PHS_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step,
  input  logic [PHS_W-1:0] offset,
  output logic [ACC_W-1:0] acc_q,
  output logic [PHS_W-1:0] phase_q
);

  localparam int TOP_LSB = ACC_W - PHS_W;

  function automatic logic [ACC_W-1:0] acc_advance(input logic [ACC_W-1:0] a,
                                                   input logic [ACC_W-1:0] s);
    return a + s;
  endfunction

  function automatic logic [PHS_W-1:0] phase_sum(input logic [ACC_W-1:0] a,
                                                 input logic [PHS_W-1:0] o);
    return a[ACC_W-1:TOP_LSB] + o;
  endfunction

  logic [ACC_W-1:0] acc_next;
  logic [PHS_W-1:0] phase_next;
  assign acc_next   = acc_advance(acc_q, step);
  assign phase_next = phase_sum(acc_q, offset);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      phase_q <= '0;
    end else begin
      acc_q   <= acc_next;
      phase_q <= phase_next;
    end
  end

  // A zero step freezes the accumulator (R1)
  assert_zero_step_holds_R1 : assert property (@(posedge clk) disable iff (rst)
    (step == '0) |=> $stable(acc_q));

  // With zero offset the phase is the old accumulator top (R3)
  assert_phase_tracks_R3 : assert property (@(posedge clk) disable iff (rst)
    (offset == '0) |=> (phase_q == $past(acc_q[ACC_W-1:TOP_LSB])));

endmodule

// File: rtl/dual_bank_nco.sv
module dual_bank_nco #(
  parameter int ACC_W       = 28,
  parameter int PHS_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             use_pins,
  input  logic             ctl_fsel,
  input  logic             ctl_psel,
  input  logic             fsel_pin,
  input  logic             psel_pin,
  output logic [ACC_W-1:0] acc_out,
  output logic [PHS_W-1:0] phase_out
);

  logic             fsel_eff;
  logic             psel_eff;
  logic [ACC_W-1:0] freq_word;
  logic [PHS_W-1:0] phase_word;

  nco_sel_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .use_pins (use_pins),
    .ctl_fsel (ctl_fsel),
    .ctl_psel (ctl_psel),
    .fsel_pin (fsel_pin),
    .psel_pin (psel_pin),
    .fsel_eff (fsel_eff),
    .psel_eff (psel_eff)
  );

  nco_word_bank #(.ACC_W(ACC_W), .PHS_W(PHS_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .fsel       (fsel_eff),
    .psel       (psel_eff),
    .freq_word  (freq_word),
    .phase_word (phase_word)
  );

  nco_phase_core #(.ACC_W(ACC_W), .PHS_W(PHS_W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step    (freq_word),
    .offset  (phase_word),
    .acc_q   (acc_out),
    .phase_q (phase_out)
  );

  // Reset empties the datapath on the next edge (R7)
  assert_reset_clears_R7 : assert property (@(posedge clk)
    rst |=> (acc_out == '0 && phase_out == '0));

endmodule

// File: tb/dual_bank_nco_bench.sv
module dual_bank_nco_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 28;
  localparam int PW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [AW-1:0] wr_data = '0;
  logic          use_pins = 1'b0;
  logic          ctl_fsel = 1'b0;
  logic          ctl_psel = 1'b0;
  logic          fsel_pin = 1'b0;
  logic          psel_pin = 1'b0;
  logic [AW-1:0] acc_out;
  logic [PW-1:0] phase_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_nco u_dual_bank_nco (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .use_pins(use_pins), .ctl_fsel(ctl_fsel), .ctl_psel(ctl_psel),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin),
    .acc_out(acc_out), .phase_out(phase_out)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string tag = "R7";

  typedef struct {
    logic [AW-1:0] acc;
    logic [PW-1:0] ph;
    string         req;
  } exp_t;
  exp_t sb[$];

  // Reference model state
  logic [AW-1:0] m_freq [2];
  logic [PW-1:0] m_off  [2];
  logic [AW-1:0] m_acc = '0;
  logic [PW-1:0] m_ph  = '0;
  logic [1:0]    m_fs  = '0;
  logic [1:0]    m_ps  = '0;

  always @(posedge clk) begin
    logic fsel_now, psel_now;
    logic [AW-1:0] n_acc;
    logic [PW-1:0] n_ph;
    exp_t e;
    fsel_now = use_pins ? m_fs[1] : ctl_fsel;
    psel_now = use_pins ? m_ps[1] : ctl_psel;
    if (rst) begin
      n_acc = '0; n_ph = '0; m_fs = '0; m_ps = '0;
    end else begin
      n_acc = m_acc + m_freq[fsel_now];
      n_ph  = PW'(m_acc[AW-1 -: PW] + m_off[psel_now]);
      m_fs  = {m_fs[0], fsel_pin};
      m_ps  = {m_ps[0], psel_pin};
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_freq[0] = wr_data;
        2'd1: m_freq[1] = wr_data;
        2'd2: m_off[0]  = wr_data[PW-1:0];
        default: m_off[1] = wr_data[PW-1:0];
      endcase
    end
    m_acc = n_acc;
    m_ph  = n_ph;
    e.acc = n_acc; e.ph = n_ph; e.req = tag;
    sb.push_back(e);
  end

  // Monitor: compares at the falling edge after each result edge
  always @(negedge clk) begin
    if (sb.size() > 0 && !done) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (acc_out !== e.acc) begin
        fails++;
        $display("FAIL %s acc_out actual=%h expected=%h", e.req, acc_out, e.acc);
      end
      checks++;
      if (phase_out !== e.ph) begin
        fails++;
        $display("FAIL %s phase_out actual=%h expected=%h", e.req, phase_out, e.ph);
      end
    end
  end

  task automatic put_word(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R7/R10: program all four words while in reset, datapath stays zero
    tag = "R7 R10 reset";
    put_word(2'd0, 28'h0000100);
    put_word(2'd1, 28'h0123457);
    put_word(2'd2, 28'h0000000);
    put_word(2'd3, 28'h0000800);
    idle(2);
    // R1 R3: bank 0 counting, zero offset
    tag = "R1 R3 count";
    rst = 1'b0;
    idle(8);
    // R2 R6: switch frequency bank by control bit, no restart
    tag = "R2 R6 fsel bit";
    ctl_fsel = 1'b1;
    idle(6);
    // R4: offset bank via control bit
    tag = "R4 psel bit";
    ctl_psel = 1'b1;
    idle(5);
    // R8: write to active bank 1 and inactive bank 0
    tag = "R8 active write";
    put_word(2'd1, 28'h0ABCDEF);
    idle(3);
    tag = "R8 inactive write";
    put_word(2'd0, 28'hFFFFFF0);
    idle(2);
    // R1 R9: near-full step wraps accumulator, 0xFFF offset wraps phase sum
    tag = "R1 R9 wrap";
    ctl_fsel = 1'b0;
    put_word(2'd3, 28'h0000FFF);
    idle(12);
    // R5: pin mode, banks follow synchronized pins
    tag = "R5 pins";
    use_pins = 1'b1;
    idle(3);
    fsel_pin = 1'b1; psel_pin = 1'b0;
    idle(4);
    fsel_pin = 1'b0; psel_pin = 1'b1;
    idle(1);
    fsel_pin = 1'b1;
    idle(5);
    // R7: mid-run reset, then words still in effect afterwards
    tag = "R7 mid reset";
    rst = 1'b1;
    idle(3);
    tag = "R7 words kept";
    rst = 1'b0;
    use_pins = 1'b0; ctl_fsel = 1'b1; ctl_psel = 1'b1;
    idle(6);
    ctl_fsel = 1'b0; ctl_psel = 1'b0;
    idle(4);
    idle(1);
    finish_run();
  end

endmodule